// File: doc/BRIEF.md
# 40-bit Free-Running Time Base

This block is a free-running up-counter that serves as a system time base. The counter is 40 bits wide. It advances by one on each clock cycle in which an external tick-enable pulse is high and counting has been switched on. The pulse arrives at a nominal 983.04 kHz; producing it from a crystal is outside this block. The counter has no reload value and raises no interrupt. When it reaches all ones it wraps to zero.

Software reaches the counter through a simple synchronous register port with two 32-bit registers. The register at offset 0x60 returns the low 32 count bits. The register at offset 0x64 holds the run control in bit 8 and returns the upper 8 count bits in bits 7:0. Reading the low register also captures the upper bits into a shadow, and the next read of the high register returns that shadow. A low read followed by a high read therefore yields one coherent 40-bit sample, even when the counter carries between the two accesses. Clearing the run bit freezes the count where it stands; the count is not cleared.

Top module: `tbase_top`

## Requirements
- R1: While rst_n is low at a clock edge, the count, the run bit, the shadow and bus_rdata all become zero.
- R2: The count rises by one at each clock edge where tick_en is high and the run bit is one. When either is low the count keeps its value, so clearing the run bit freezes the count without clearing it.
- R3: A write to offset 0x64 loads the run bit from bus_wdata[8] at that clock edge. A tick in the same cycle as the write is judged against the run bit as it was before the write.
- R4: A read of offset 0x60 puts the count's low 32 bits, as they stood before that cycle's tick, on bus_rdata. The value appears from the next clock edge.
- R5: A read of offset 0x60 copies count bits 39:32 into the shadow, and nothing else changes the shadow. A read of offset 0x64 returns the shadow in bits 7:0 and the run bit in bit 8, with zero in all other bits.
- R6: The count wraps from all ones to zero and keeps counting.
- R7: Writes to offset 0x60, and bits other than bit 8 of a write to 0x64, change nothing. The count cannot be written.
- R8: A read of any other offset returns zero. bus_rdata holds its last value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse, one cycle per tick |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |

## Verification
The critical coincidence is a low-register read in the same cycle as a tick that carries out of the low 32 bits. A narrow instance with an 8-bit low field lets the bench reach such a carry within a short run. The bench counts up to 255 and then issues the low read with tick_en high. It expects the pre-carry low value, and it expects a following high read to return the pre-carry upper bits from the shadow, not the live count. A second coincidence is a run-bit write together with a tick. The bench judges that case against the run bit as it stood before the write.

// File: rtl/tbase_pkg.sv
// Package: tbase_pkg
// Shared register offsets, field positions and the decoded access kind
// for the free-running time base. Assumes byte offsets on an 8-bit bus.
package tbase_pkg;

    localparam logic [7:0] OFF_CNT_LO = 8'h60;
    localparam logic [7:0] OFF_CNT_HI = 8'h64;
    localparam int         RUN_BIT    = 8;

    typedef enum logic [2:0] {
        ACC_IDLE     = 3'd0,
        ACC_RD_LO    = 3'd1,
        ACC_RD_HI    = 3'd2,
        ACC_RD_OTHER = 3'd3,
        ACC_WR_HI    = 3'd4,
        ACC_WR_OTHER = 3'd5
    } acc_kind_t;

endpackage

// File: rtl/tbase_decode.sv
// Module: tbase_decode
// Turns one bus cycle into an access kind. Purely combinational.
// Assumes a single-cycle access qualified by sel; addresses are byte offsets.
module tbase_decode
    import tbase_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind
);

    logic hit_lo;
    logic hit_hi;

    assign hit_lo = (addr == ADDR_W'(OFF_CNT_LO));
    assign hit_hi = (addr == ADDR_W'(OFF_CNT_HI));

    // Classify the access by direction and target register.
    always_comb begin
        kind = ACC_IDLE;
        if (sel) begin
            if (wr) begin
                kind = hit_hi ? ACC_WR_HI : ACC_WR_OTHER;
            end else if (hit_lo) begin
                kind = ACC_RD_LO;
            end else if (hit_hi) begin
                kind = ACC_RD_HI;
            end else begin
                kind = ACC_RD_OTHER;
            end
        end
    end

endmodule

// File: rtl/tbase_count.sv
// Module: tbase_count
// Free-running up-counter that advances on tick while run is set and
// wraps naturally at its width. Assumes tick is already synchronous to clk.
module tbase_count #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count_q
);

    // Advance the count by one per qualified tick; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run && tick) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbase_regs.sv
// Module: tbase_regs
// Holds the run bit and the upper-bit shadow, and forms the registered
// read data. Assumes HIGH_W <= RUN_BIT and LOW_W <= DATA_W.
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 8,
    parameter int DATA_W = 32,
    localparam int CNT_W = LOW_W + HIGH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_t         kind,
    input  logic              wr_run,
    input  logic [CNT_W-1:0]  count,
    output logic              run_q,
    output logic [HIGH_W-1:0] shadow_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] lo_word;
    logic [DATA_W-1:0] hi_word;

    // Run bit: loaded only by writes to the high register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (kind == ACC_WR_HI) begin
            run_q <= wr_run;
        end
    end

    // Shadow: captures the upper count bits on every low-register read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (kind == ACC_RD_LO) begin
            shadow_q <= count[CNT_W-1:LOW_W];
        end
    end

    // Low word: count low field, zero-extended to the bus width.
    always_comb begin
        lo_word = '0;
        lo_word[LOW_W-1:0] = count[LOW_W-1:0];
    end

    // High word: shadow in the bottom bits, run bit at its fixed position.
    always_comb begin
        hi_word = '0;
        hi_word[HIGH_W-1:0] = shadow_q;
        hi_word[RUN_BIT]    = run_q;
    end

    // Read data register: updates on reads only, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            case (kind)
                ACC_RD_LO:    rdata_q <= lo_word;
                ACC_RD_HI:    rdata_q <= hi_word;
                ACC_RD_OTHER: rdata_q <= '0;
                default:      rdata_q <= rdata_q;
            endcase
        end
    end

endmodule

// File: rtl/tbase_top.sv
// Module: tbase_top
// Free-running time base with a two-register read window and a run bit.
// Assumes tick_en is a one-cycle clock-enable pulse and the bus issues at
// most one access per cycle. Read data is valid one cycle after the read.
module tbase_top
    import tbase_pkg::*;
#(
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CNT_W = LOW_W + HIGH_W;

    acc_kind_t         kind;
    logic              run_q;
    logic [HIGH_W-1:0] shadow_q;
    logic [CNT_W-1:0]  count_q;
    logic              unused_wdata;

    // Only the run bit of the write data is stored.
    assign unused_wdata = ^bus_wdata;

    tbase_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .kind (kind)
    );

    tbase_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .tick    (tick_en),
        .count_q (count_q)
    );

    tbase_regs #(
        .LOW_W  (LOW_W),
        .HIGH_W (HIGH_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .wr_run   (bus_wdata[RUN_BIT]),
        .count    (count_q),
        .run_q    (run_q),
        .shadow_q (shadow_q),
        .rdata_q  (bus_rdata)
    );

endmodule

// File: rtl/tbase_chk.sv
// Module: tbase_chk
// Property checker for tbase_top, attached with bind. Decodes the bus on
// its own and relates the count, run bit, shadow and read data over time.
module tbase_chk #(
    parameter int LOW_W  = 32,
    parameter int HIGH_W = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick_en,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      wr_run,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [LOW_W+HIGH_W-1:0]   count_q,
    input logic                      run_q,
    input logic [HIGH_W-1:0]         shadow_q
);

    localparam int CNT_W = LOW_W + HIGH_W;

    logic rd_lo;
    logic rd_other;
    logic wr_hi;

    assign rd_lo    = bus_sel && !bus_wr && (bus_addr == ADDR_W'(8'h60));
    assign rd_other = bus_sel && !bus_wr && (bus_addr != ADDR_W'(8'h60))
                      && (bus_addr != ADDR_W'(8'h64));
    assign wr_hi    = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h64));

    // R1: reset clears count, run bit, shadow and read data
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0 && !run_q && shadow_q == '0 && bus_rdata == '0));

    // R2, R6: qualified tick advances by one, wrapping at full width
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_en) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    // R2: no qualified tick, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_q && tick_en) |=> $stable(count_q));

    // R3: run bit follows the written bit
    a_r3_run_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (run_q == $past(wr_run)));

    // R4: low read returns the pre-tick low field
    a_r4_low_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (bus_rdata[LOW_W-1:0] == $past(count_q[LOW_W-1:0])));

    // R5: shadow captures upper bits on a low read only
    a_r5_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow_q == $past(count_q[CNT_W-1:LOW_W])));

    a_r5_shadow_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(shadow_q));

    // R8: unmapped reads return zero; idle cycles hold the read data
    a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |=> (bus_rdata == '0));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(bus_rdata));

endmodule

bind tbase_top tbase_chk #(
    .LOW_W  (LOW_W),
    .HIGH_W (HIGH_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_run    (bus_wdata[8]),
    .bus_rdata (bus_rdata),
    .count_q   (count_q),
    .run_q     (run_q),
    .shadow_q  (shadow_q)
);

// File: tb/tbase_top_tb_top.sv
// Bench for tbase_top: a full-width instance plus a narrow instance
// (8-bit low field) that makes carries and wrap reachable in a short run.
module tbase_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_w;
    logic [31:0] rdata_n;

    int checks = 0;
    int failures = 0;

    // Bench model
    logic [39:0] m_cnt = '0;
    logic        m_run = 1'b0;
    logic [7:0]  m_sh_w = '0;
    logic [7:0]  m_sh_n = '0;

    always #2 clk = ~clk;   // 250 MHz

    tbase_top dut_i (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (rdata_w)
    );

    tbase_top #(.LOW_W(8), .HIGH_W(8)) dut_n (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (rdata_n)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read, 2 tick burst
        logic [7:0]  addr;
        logic [31:0] data;
        logic [15:0] n;
        logic [31:0] exp;   // expected full-width read data
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h60, 32'h0,        16'd0,  32'h0},    // R1
        '{2'd1, 8'h64, 32'h0,        16'd0,  32'h0},    // R1
        '{2'd2, 8'h00, 32'h0,        16'd4,  32'h0},    // R2 not running
        '{2'd1, 8'h60, 32'h0,        16'd0,  32'h0},    // R2
        '{2'd0, 8'h64, 32'h100,      16'd0,  32'h0},    // R3 start
        '{2'd2, 8'h00, 32'h0,        16'd10, 32'h0},
        '{2'd1, 8'h60, 32'h0,        16'd0,  32'd10},   // R4
        '{2'd1, 8'h64, 32'h0,        16'd0,  32'h100},  // R5
        '{2'd0, 8'h64, 32'h0FF,      16'd0,  32'h0},    // R7 count bits ignored, stop
        '{2'd2, 8'h00, 32'h0,        16'd7,  32'h0},
        '{2'd1, 8'h60, 32'h0,        16'd0,  32'd10},   // R2 frozen
        '{2'd1, 8'h64, 32'h0,        16'd0,  32'h0},    // R3 run bit cleared
        '{2'd0, 8'h60, 32'hDEAD,     16'd0,  32'h0},    // R7 low write ignored
        '{2'd1, 8'h60, 32'h0,        16'd0,  32'd10},   // R7
        '{2'd1, 8'h68, 32'h0,        16'd0,  32'h0}     // R8 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Apply a tick in the model (run bit judged before any write).
    task automatic model_tick(input logic t);
        if (t && m_run) m_cnt = m_cnt + 40'd1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
        model_tick(t);
        if (a == 8'h64) m_run = d[8];
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic t, input string req);
        logic [31:0] ew;
        logic [31:0] en;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; tick_en = t;
        if (a == 8'h60) begin
            ew = m_cnt[31:0];
            en = {24'h0, m_cnt[7:0]};
            m_sh_w = m_cnt[39:32];
            m_sh_n = m_cnt[15:8];
        end else if (a == 8'h64) begin
            ew = {23'h0, m_run, m_sh_w};
            en = {23'h0, m_run, m_sh_n};
        end else begin
            ew = '0;
            en = '0;
        end
        model_tick(t);
        @(negedge clk);
        bus_sel = 1'b0; tick_en = 1'b0;
        check({req, " wide"}, rdata_w, ew);
        check({req, " narrow"}, rdata_n, en);
    endtask

    task automatic do_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            model_tick(1'b1);
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = '0; m_run = 1'b0; m_sh_w = '0; m_sh_n = '0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: read data is zero straight after reset
        check("R1 rdata after reset", rdata_w, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                2'd0: do_write(VECS[k].addr, VECS[k].data, 1'b0);
                2'd1: begin
                    do_read(VECS[k].addr, 1'b0, "R4/R5/R8 table");
                    check("R2 table vector", rdata_w, VECS[k].exp);
                end
                default: do_ticks(int'(VECS[k].n));
            endcase
        end

        // R1: reset in mid-run clears the count and the run bit
        do_write(8'h64, 32'h100, 1'b0);
        do_ticks(9);
        do_read(8'h60, 1'b0, "R1 pre-reset");
        do_reset();
        do_read(8'h60, 1'b0, "R1 count cleared");
        do_read(8'h64, 1'b0, "R1 run cleared");
        do_ticks(5);
        do_read(8'h60, 1'b0, "R1 no count after reset");

        // R3: run write with a tick in the same cycle; that tick is not counted
        do_write(8'h64, 32'h100, 1'b1);
        do_read(8'h60, 1'b0, "R3 tick in start cycle");

        // R5: low read coinciding with a tick that carries into the upper bits
        do_ticks(255);
        do_read(8'h60, 1'b1, "R5 low read at carry");
        do_read(8'h64, 1'b0, "R5 shadow pre-carry");
        do_read(8'h60, 1'b0, "R4 low after carry");
        do_read(8'h64, 1'b0, "R5 shadow post-carry");
        do_ticks(300);
        do_read(8'h64, 1'b0, "R5 shadow held across ticks");

        // R3: stop write with a tick in the same cycle; that tick counts
        do_write(8'h64, 32'h0, 1'b1);
        do_ticks(20);
        do_read(8'h60, 1'b0, "R2 frozen after stop");
        do_read(8'h64, 1'b0, "R3 stopped");

        // R6: wrap of the narrow instance
        do_write(8'h64, 32'hFFFF_FFFF, 1'b0);
        do_ticks(65535 - int'(m_cnt[15:0]));
        do_read(8'h60, 1'b0, "R6 all ones low");
        do_read(8'h64, 1'b0, "R6 all ones high");
        do_ticks(1);
        do_read(8'h60, 1'b0, "R6 wrapped low");
        do_read(8'h64, 1'b0, "R6 wrapped high");

        // R8: unmapped read, then idle hold
        do_read(8'h10, 1'b0, "R8 unmapped");
        do_ticks(3);
        check("R8 idle hold", rdata_w, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule